// File: doc/BRIEF.md
# Clock Power-Down and Warm-Reset Sequencer

This block is the control state machine that takes a processor core's clock generator down into a low-power sleep state and brings it back up. A sleep request from the core walks the machine through three timed ramp-down steps. The last step stops the internal clocks and parks the machine until an asynchronous wake-up interrupt arrives. The wake-up path has two timed ramp-up steps. It then waits in order for the system to assert the clock-forwarding reset, for the core's self-test to finish, and for the system to release the clock-forwarding reset. Only after that does it return to the running state.

A warm reset takes the same ramp-down path and ends in a separate park state. That happens when the active-low warm-reset input is seen asserted while the machine is running. In the first cycle in that park state, the block pulses four register-initialisation strobes: clear the trap-handler base, clear the core control register, set the floating-point enable in the process context, and reload the configuration chain with the board-level cache switched off. When the warm reset is released, the ramp-up path starts. The wake-up interrupt, the warm-reset input and the clock-forward reset input each pass through a two-flop synchroniser first. The sleep request and the self-test indication are taken as synchronous to the block clock.

Top module: `power_seq_ctl`

## Requirements
- R1: After power-on reset (`por_n` low) the sequencer is in the running state, with `seq_state` = 0 and `core_clk_en` = 1. `fwd_rst_int`, both ramp outputs and all four init strobes are 0.
- R2: A sleep request seen in the running state moves the machine through steps 1, 2 and 3 of the ramp-down and then into sleep (`seq_state` 1, 2, 3, 4). Each ramp-down step lasts exactly DWELL cycles.
- R3: A synchronised wake-up seen in sleep moves the machine through ramp-up steps 6 and 7, each lasting DWELL cycles. It then visits wait-forward-reset-on (8), self-init (9) and wait-forward-reset-off (10), and returns to running (0).
- R4: A warm reset seen in the running state takes the same ramp-down path but ends in the reset park state (5) instead of sleep. When the warm reset and a sleep request are seen in the same cycle, the warm reset wins.
- R5: `clr_trap_base`, `clr_core_ctl`, `set_fp_ctx` and `init_cfg_chain` are high for exactly the first cycle the machine spends in state 5, and are low at all other times.
- R6: A change on `wake_irq`, `warm_rst_n` or `fwd_rst_in` is acted on at the third rising clock edge after it is applied, and not before.
- R7: State 8 holds until the synchronised `fwd_rst_in` is high. State 10 holds until it is low.
- R8: State 9 holds until `selftest_done` is high, and leaves on the edge where it is sampled high.
- R9: `core_clk_en` is 0 in states 3 through 10 and 1 in states 0, 1 and 2. `fwd_rst_int` is 1 in states 2 through 10 and 0 in states 0 and 1.
- R10: `pll_ramp_dn` is 1 exactly in states 1 to 3. `pll_ramp_up` is 1 exactly in states 6 and 7.
- R11: The reset park state ignores `wake_irq` and leaves for state 6 only when the warm reset is seen released. A sleep request outside the running state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req | input | 1 | Request to enter sleep (synchronous) |
| wake_irq | input | 1 | Wake-up interrupt (asynchronous) |
| warm_rst_n | input | 1 | Warm reset, active low (asynchronous) |
| fwd_rst_in | input | 1 | Clock-forwarding reset driven by the system (asynchronous) |
| selftest_done | input | 1 | Self-initialisation complete (synchronous) |
| core_clk_en | output | 1 | Enable for the core's internal clocks |
| fwd_rst_int | output | 1 | Internal clock-forwarding reset |
| pll_ramp_dn | output | 1 | PLL ramp-down control |
| pll_ramp_up | output | 1 | PLL ramp-up control |
| clr_trap_base | output | 1 | Strobe: clear trap-handler base register |
| clr_core_ctl | output | 1 | Strobe: clear core control register |
| set_fp_ctx | output | 1 | Strobe: set floating-point enable in process context |
| init_cfg_chain | output | 1 | Strobe: reload configuration chain, board cache off |
| seq_state | output | 4 | Current sequencer state code |

## Verification
On every cycle the assertions check the legal successor of each state. They also check that the three wait states hold while their condition is absent, that the reset park state holds under an active warm reset, that the init strobes last a single cycle and occur only in the park state, and that clocks are only re-enabled on the return to running. The exact dwell lengths, the three-edge synchroniser latency, the warm-reset priority over sleep, and the ignored wake-up and sleep inputs can only be shown by the bench's timed scenarios, which compare the state code and outputs at computed cycles.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [3:0] {
    S_RUN     = 4'd0,
    S_DN1     = 4'd1,
    S_DN2     = 4'd2,
    S_DN3     = 4'd3,
    S_SLEEP   = 4'd4,
    S_PARK    = 4'd5,
    S_UP1     = 4'd6,
    S_UP2     = 4'd7,
    S_FWD_ON  = 4'd8,
    S_INIT    = 4'd9,
    S_FWD_OFF = 4'd10
  } seq_st_t;

  // states that hold for a fixed number of cycles
  function automatic logic f_timed(input seq_st_t s);
    return (s == S_DN1) || (s == S_DN2) || (s == S_DN3) ||
           (s == S_UP1) || (s == S_UP2);
  endfunction

  // internal clocks stopped
  function automatic logic f_clk_off(input seq_st_t s);
    return (s >= S_DN3) && (s <= S_FWD_OFF);
  endfunction

  // internal clock-forward reset held
  function automatic logic f_fwd_hold(input seq_st_t s);
    return (s >= S_DN2) && (s <= S_FWD_OFF);
  endfunction

  function automatic logic f_ramp_dn(input seq_st_t s);
    return (s >= S_DN1) && (s <= S_DN3);
  endfunction

  function automatic logic f_ramp_up(input seq_st_t s);
    return (s == S_UP1) || (s == S_UP2);
  endfunction

  // last cycle of a dwell window
  function automatic logic f_dwell_last(input int unsigned cnt, input int unsigned dwell);
    return cnt == (dwell - 1);
  endfunction

endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain[g] <= RST_VAL;
        else        chain[g] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/psq_dwell.sv
module psq_dwell
  import psq_pkg::*;
#(
  parameter int unsigned DWELL = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick_en,
  output logic dwell_done
);

  localparam int unsigned CW = (DWELL < 2) ? 1 : $clog2(DWELL);

  logic [CW-1:0] cnt;

  assign dwell_done = tick_en && f_dwell_last(int'(cnt), DWELL);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      cnt <= '0;
    else if (!tick_en || dwell_done) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!por_n)
    int'(cnt) < DWELL); // R2

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    !tick_en |=> cnt == '0); // R2

endmodule

// File: rtl/psq_fsm.sv
module psq_fsm
  import psq_pkg::*;
(
  input  logic    clk,
  input  logic    por_n,
  input  logic    sleep_req,
  input  logic    wake_seen,
  input  logic    warm_req,
  input  logic    fwd_seen,
  input  logic    selftest_done,
  input  logic    dwell_done,
  output seq_st_t st,
  output logic    tick_en,
  output logic    park_entry
);

  seq_st_t nxt;
  logic    rpath, nxt_rpath;

  always_comb begin
    nxt       = st;
    nxt_rpath = rpath;
    case (st)
      S_RUN: begin
        if (warm_req) begin
          nxt       = S_DN1;
          nxt_rpath = 1'b1;
        end else if (sleep_req) begin
          nxt       = S_DN1;
          nxt_rpath = 1'b0;
        end
      end
      S_DN1:     if (dwell_done) nxt = S_DN2;
      S_DN2:     if (dwell_done) nxt = S_DN3;
      S_DN3:     if (dwell_done) nxt = rpath ? S_PARK : S_SLEEP;
      S_SLEEP:   if (wake_seen) nxt = S_UP1;
      S_PARK:    if (!warm_req) nxt = S_UP1;
      S_UP1:     if (dwell_done) nxt = S_UP2;
      S_UP2:     if (dwell_done) nxt = S_FWD_ON;
      S_FWD_ON:  if (fwd_seen) nxt = S_INIT;
      S_INIT:    if (selftest_done) nxt = S_FWD_OFF;
      S_FWD_OFF: if (!fwd_seen) nxt = S_RUN;
      default:   nxt = S_RUN;
    endcase
  end

  assign tick_en    = f_timed(st);
  assign park_entry = (nxt == S_PARK) && (st != S_PARK);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st    <= S_RUN;
      rpath <= 1'b0;
    end else begin
      st    <= nxt;
      rpath <= nxt_rpath;
    end
  end

  AST_DN1_NEXT: assert property (@(posedge clk) disable iff (!por_n)
    st == S_DN1 |=> st inside {S_DN1, S_DN2}); // R2
  AST_DN2_NEXT: assert property (@(posedge clk) disable iff (!por_n)
    st == S_DN2 |=> st inside {S_DN2, S_DN3}); // R2
  AST_DN3_NEXT: assert property (@(posedge clk) disable iff (!por_n)
    st == S_DN3 |=> st inside {S_DN3, S_SLEEP, S_PARK}); // R4
  AST_SLEEP_NEXT: assert property (@(posedge clk) disable iff (!por_n)
    st == S_SLEEP |=> st inside {S_SLEEP, S_UP1}); // R3
  AST_UP1_NEXT: assert property (@(posedge clk) disable iff (!por_n)
    st == S_UP1 |=> st inside {S_UP1, S_UP2}); // R3
  AST_UP2_NEXT: assert property (@(posedge clk) disable iff (!por_n)
    st == S_UP2 |=> st inside {S_UP2, S_FWD_ON}); // R3
  AST_FWD_ON_WAIT: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_FWD_ON && !fwd_seen) |=> st == S_FWD_ON); // R7
  AST_FWD_OFF_WAIT: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_FWD_OFF && fwd_seen) |=> st == S_FWD_OFF); // R7
  AST_INIT_WAIT: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_INIT && !selftest_done) |=> st == S_INIT); // R8
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_PARK && warm_req) |=> st == S_PARK); // R11
  AST_RUN_STAY: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_RUN && !warm_req && !sleep_req) |=> st == S_RUN); // R11

endmodule

// File: rtl/psq_outdec.sv
module psq_outdec
  import psq_pkg::*;
(
  input  logic    clk,
  input  logic    por_n,
  input  seq_st_t st,
  input  logic    park_entry,
  output logic    clk_en,
  output logic    fwd_int,
  output logic    ramp_dn,
  output logic    ramp_up,
  output logic    init_pulse
);

  assign clk_en  = !f_clk_off(st);
  assign fwd_int = f_fwd_hold(st);
  assign ramp_dn = f_ramp_dn(st);
  assign ramp_up = f_ramp_up(st);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) init_pulse <= 1'b0;
    else        init_pulse <= park_entry;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    init_pulse |=> !init_pulse); // R5
  AST_STROBE_IN_PARK: assert property (@(posedge clk) disable iff (!por_n)
    init_pulse |-> st == S_PARK); // R5
  AST_CLK_BACK_IN_RUN: assert property (@(posedge clk) disable iff (!por_n)
    $rose(clk_en) |-> st == S_RUN); // R9
  AST_RAMPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_n)
    !(ramp_dn && ramp_up)); // R10

endmodule

// File: rtl/power_seq_ctl.sv
module power_seq_ctl
  import psq_pkg::*;
#(
  parameter int unsigned DWELL       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sleep_req,
  input  logic       wake_irq,
  input  logic       warm_rst_n,
  input  logic       fwd_rst_in,
  input  logic       selftest_done,
  output logic       core_clk_en,
  output logic       fwd_rst_int,
  output logic       pll_ramp_dn,
  output logic       pll_ramp_up,
  output logic       clr_trap_base,
  output logic       clr_core_ctl,
  output logic       set_fp_ctx,
  output logic       init_cfg_chain,
  output logic [3:0] seq_state
);

  localparam int unsigned NSYNC = 3;
  // bit order: {fwd, warm_n, wake}; warm_n idles high
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b010;

  logic [NSYNC-1:0] raw_in, synced;
  logic             wake_seen, warm_req, fwd_seen;
  logic             tick_en, dwell_done, park_entry, init_pulse;
  seq_st_t          st;

  assign raw_in    = {fwd_rst_in, warm_rst_n, wake_irq};
  assign wake_seen = synced[0];
  assign warm_req  = !synced[1];
  assign fwd_seen  = synced[2];

  psq_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk    (clk),
    .por_n  (por_n),
    .d_async(raw_in),
    .q_sync (synced)
  );

  psq_dwell #(.DWELL(DWELL)) u_dwell (
    .clk       (clk),
    .por_n     (por_n),
    .tick_en   (tick_en),
    .dwell_done(dwell_done)
  );

  psq_fsm u_fsm (
    .clk          (clk),
    .por_n        (por_n),
    .sleep_req    (sleep_req),
    .wake_seen    (wake_seen),
    .warm_req     (warm_req),
    .fwd_seen     (fwd_seen),
    .selftest_done(selftest_done),
    .dwell_done   (dwell_done),
    .st           (st),
    .tick_en      (tick_en),
    .park_entry   (park_entry)
  );

  psq_outdec u_out (
    .clk       (clk),
    .por_n     (por_n),
    .st        (st),
    .park_entry(park_entry),
    .clk_en    (core_clk_en),
    .fwd_int   (fwd_rst_int),
    .ramp_dn   (pll_ramp_dn),
    .ramp_up   (pll_ramp_up),
    .init_pulse(init_pulse)
  );

  assign clr_trap_base  = init_pulse;
  assign clr_core_ctl   = init_pulse;
  assign set_fp_ctx     = init_pulse;
  assign init_cfg_chain = init_pulse;
  assign seq_state      = st;

  AST_WAKE_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_SLEEP && wake_seen) |=> st == S_UP1); // R3
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_RUN && warm_req && sleep_req) |=> st == S_DN1 ##1 st != S_RUN); // R4

endmodule

// File: tb/sim_power_seq_ctl.sv
module sim_power_seq_ctl;

  localparam int unsigned DW = 4;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic por_n, sleep_req, wake_irq, warm_rst_n, fwd_rst_in, selftest_done;
  logic core_clk_en, fwd_rst_int, pll_ramp_dn, pll_ramp_up;
  logic clr_trap_base, clr_core_ctl, set_fp_ctx, init_cfg_chain;
  logic [3:0] seq_state;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  power_seq_ctl #(.DWELL(DW)) u0 (
    .clk(clk), .por_n(por_n), .sleep_req(sleep_req), .wake_irq(wake_irq),
    .warm_rst_n(warm_rst_n), .fwd_rst_in(fwd_rst_in), .selftest_done(selftest_done),
    .core_clk_en(core_clk_en), .fwd_rst_int(fwd_rst_int), .pll_ramp_dn(pll_ramp_dn),
    .pll_ramp_up(pll_ramp_up), .clr_trap_base(clr_trap_base), .clr_core_ctl(clr_core_ctl),
    .set_fp_ctx(set_fp_ctx), .init_cfg_chain(init_cfg_chain), .seq_state(seq_state)
  );

  // {sleep, wake, warm_n, fwd, stdone, ncyc[3:0], state[3:0], clk_en, fwd_int}
  localparam logic [14:0] VEC [NV] = '{
    {5'b10100, 4'd1, 4'd1,  2'b10},  // R2 enter step 1
    {5'b00100, 4'd3, 4'd1,  2'b10},  // R2 step 1 dwell
    {5'b00100, 4'd1, 4'd2,  2'b11},  // R2 step 2
    {5'b00100, 4'd4, 4'd3,  2'b01},  // R2 step 3
    {5'b00110, 4'd4, 4'd4,  2'b01},  // R2 sleep
    {5'b01110, 4'd2, 4'd4,  2'b01},  // R6 wake not yet seen
    {5'b01110, 4'd1, 4'd6,  2'b01},  // R3 ramp-up 1
    {5'b00110, 4'd4, 4'd7,  2'b01},  // R3 ramp-up 2
    {5'b00110, 4'd4, 4'd8,  2'b01},  // R3 wait fwd on
    {5'b00110, 4'd1, 4'd9,  2'b01},  // R7 fwd seen -> init
    {5'b10110, 4'd3, 4'd9,  2'b01},  // R8 R11 init holds, sleep ignored
    {5'b00111, 4'd1, 4'd10, 2'b01},  // R8 self-test done
    {5'b00100, 4'd2, 4'd10, 2'b01},  // R7 fwd release not yet seen
    {5'b00100, 4'd1, 4'd0,  2'b10}   // R3 R9 back to run
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    por_n = 1'b0; sleep_req = 1'b0; wake_irq = 1'b0; warm_rst_n = 1'b1;
    fwd_rst_in = 1'b0; selftest_done = 1'b0;
    step(3);
    // R1 reset state
    chk("R1 state", seq_state, 0);
    chk("R1 clk_en", core_clk_en, 1);
    chk("R1 fwd_int", fwd_rst_int, 0);
    chk("R1 ramps", {pll_ramp_dn, pll_ramp_up}, 0);
    chk("R1 strobes", {clr_trap_base, clr_core_ctl, set_fp_ctx, init_cfg_chain}, 0);
    por_n = 1'b1;
    step(2);

    // table walk: sleep and wake round trip
    for (int i = 0; i < NV; i++) begin
      {sleep_req, wake_irq, warm_rst_n, fwd_rst_in, selftest_done} = VEC[i][14:10];
      step(int'(VEC[i][9:6]));
      chk($sformatf("R2/R3 vec%0d state", i), seq_state, int'(VEC[i][5:2]));
      chk($sformatf("R9 vec%0d clk_en", i), core_clk_en, int'(VEC[i][1]));
      chk($sformatf("R9 vec%0d fwd_int", i), fwd_rst_int, int'(VEC[i][0]));
    end

    // R6 R4 warm reset with priority over sleep
    warm_rst_n = 1'b0;
    step(2);
    chk("R6 warm not yet seen", seq_state, 0);
    sleep_req = 1'b1;
    step(1);
    chk("R4 warm+sleep -> step 1", seq_state, 1);
    chk("R10 ramp_dn in step 1", pll_ramp_dn, 1);
    sleep_req = 1'b0;
    step(3 * DW - 1);
    chk("R4 still step 3", seq_state, 3);
    chk("R5 no strobe before park", clr_trap_base, 0);
    step(1);
    chk("R4 parked after reset path", seq_state, 5);
    chk("R5 strobes on park entry", {clr_trap_base, clr_core_ctl, set_fp_ctx, init_cfg_chain}, 15);
    step(1);
    chk("R5 strobes one cycle", {clr_trap_base, clr_core_ctl, set_fp_ctx, init_cfg_chain}, 0);

    // R11 wake and sleep ignored in park
    wake_irq = 1'b1; sleep_req = 1'b1;
    step(6);
    chk("R11 wake ignored in park", seq_state, 5);
    wake_irq = 1'b0; sleep_req = 1'b0;
    step(3);

    // R11 release warm reset -> ramp-up
    warm_rst_n = 1'b1;
    step(2);
    chk("R6 release not yet seen", seq_state, 5);
    step(1);
    chk("R11 park -> ramp-up 1", seq_state, 6);
    chk("R10 ramp_up in ramp-up 1", pll_ramp_up, 1);
    chk("R10 ramp_dn off in ramp-up", pll_ramp_dn, 0);
    step(2 * DW);
    chk("R3 wait fwd on", seq_state, 8);

    // R7 hold without forward reset
    step(6);
    chk("R7 holds without fwd reset", seq_state, 8);
    fwd_rst_in = 1'b1;
    step(2);
    chk("R6 fwd not yet seen", seq_state, 8);
    step(1);
    chk("R7 fwd seen -> init", seq_state, 9);
    step(4);
    chk("R8 init waits", seq_state, 9);
    selftest_done = 1'b1;
    step(1);
    chk("R8 init done", seq_state, 10);
    selftest_done = 1'b0;
    step(5);
    chk("R7 holds while fwd asserted", seq_state, 10);
    fwd_rst_in = 1'b0;
    step(3);
    chk("R3 back in run", seq_state, 0);
    chk("R9 clk_en in run", core_clk_en, 1);
    chk("R10 ramps off in run", {pll_ramp_dn, pll_ramp_up}, 0);

    // R2 sleep path again ends in sleep, not park
    sleep_req = 1'b1;
    step(1);
    sleep_req = 1'b0;
    step(3 * DW);
    chk("R2 sleep path ends in sleep", seq_state, 4);
    chk("R5 no strobes on sleep", clr_core_ctl, 0);

    finish_run();
  end

endmodule